// File: doc/BRIEF.md
# Level/Edge Interrupt Aggregator

This block gathers thirty-two raw interrupt lines into one registered request for a parent processor. Each line passes through a two-flop synchroniser. A per-line pair of configuration bits selects how the line raises its pending bit: a trigger-mode bit chooses level or edge, and a polarity bit chooses active-high/rising or active-low/falling.

Software sees six 32-bit words on a simple read/write bus. Bit n of every word belongs to line n. It reads the pending word and masks lines with the enable word. It acknowledges latched edges by writing ones to a clear word, and it raises software interrupts by writing ones to a set word. The parent request is high whenever any line is both pending and enabled. Finding which line to serve is left to software, which scans for the lowest set bit.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is high and on the first edge after it, the enable, polarity and trigger-mode words read as zero and `irq_out` is low.
- R2: Word offsets are pending 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10, trigger-mode 0x14, all 4-byte aligned. Enable, polarity and trigger-mode read back what was written. The set word, the clear word and any other offset read as zero. Read data appears on the clock edge that samples `bus_rd`.
- R3: With trigger-mode bit 0, the pending bit is 1 exactly when the synchronised input equals the polarity bit (polarity 1: active high, polarity 0: active low).
- R4: With trigger-mode bit 1, the pending bit becomes 1 on a rising input edge when polarity is 1, or on a falling edge when polarity is 0. It then stays 1 after the input returns.
- R5: Writing ones to the clear word clears the matching pending bits of edge-mode lines. Zero bits leave their lines untouched.
- R6: If an edge-mode line sees its selected transition in the same cycle as a clear of that bit, the pending bit ends at 1.
- R7: A clear of a level-mode line whose input is still active has no lasting effect: the pending bit reads 1 afterwards.
- R8: Writing ones to the set word forces the matching pending bits to 1. On edge-mode lines they stay 1 until cleared.
- R9: `irq_out` is the registered OR over all lines of pending AND enable. A pending line whose enable bit is 0 does not raise it.
- R10: On an enabled level line, an input change driven between clock edges reaches `irq_out` on the fourth rising edge after it: two synchroniser stages, the pending register, then the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Registered read data |
| irq_lines | input | NUM_LINES | Raw asynchronous interrupt inputs |
| irq_out | output | 1 | Registered combined request to the parent |

## Verification
The bus carries one write per cycle, so the set word and the clear word can never act together. Two other pairs of functions can share a cycle.

The first pair is a detected edge and a software clear on the same line. The bench provokes it by counting the synchroniser stages and issuing the clear write so that it commits on exactly the edge where the transition is detected. It then reads back and expects the pending bit to be 1.

The second pair is a level-active line and a clear aimed at it. The bench holds the input active, writes the clear, and expects the pending bit still set on the next read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // word index taken from address bits [4:2]
  typedef enum logic [2:0] {
    SEL_PEND = 3'd0,
    SEL_EN   = 3'd1,
    SEL_SET  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_POL  = 3'd4,
    SEL_MODE = 3'd5
  } reg_sel_e;

  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      mode_q,
  output logic [W-1:0]      set_mask,
  output logic [W-1:0]      clr_mask,
  output logic [W-1:0]      rdata
);
  localparam int HI_LSB = SEL_LSB + SEL_W;

  logic     hit;
  reg_sel_e sel;
  logic [W-1:0] rd_val;

  assign hit = (addr[ADDR_W-1:HI_LSB] == '0) && (addr[SEL_LSB-1:0] == '0);
  assign sel = reg_sel_e'(addr[HI_LSB-1:SEL_LSB]);

  assign set_mask = (wr && hit && sel == SEL_SET) ? wdata : '0;
  assign clr_mask = (wr && hit && sel == SEL_CLR) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (wr && hit) begin
      case (sel)
        SEL_EN:   en_q   <= wdata;
        SEL_POL:  pol_q  <= wdata;
        SEL_MODE: mode_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND: rd_val = pend;
      SEL_EN:   rd_val = en_q;
      SEL_POL:  rd_val = pol_q;
      SEL_MODE: rd_val = mode_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= hit ? rd_val : '0;
  end
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_s,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= line_s;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    logic active, edge_hit, nxt;
    assign active   = pol[i] ? line_s[i] : ~line_s[i];
    assign edge_hit = pol[i] ? (line_s[i] & ~prev[i]) : (~line_s[i] & prev[i]);
    // set beats clear; a fresh edge beats clear
    assign nxt = mode[i] ? (edge_hit | set_mask[i] | (pend[i] & ~clr_mask[i]))
                         : (active | set_mask[i]);
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= nxt;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_LINES   = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] line_s, pend_q, en_q, pol_q, mode_q, set_mask, clr_mask;

  irq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_lines), .q(line_s)
  );

  irq_regfile #(.W(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .pend(pend_q), .en_q(en_q), .pol_q(pol_q),
    .mode_q(mode_q), .set_mask(set_mask), .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  irq_capture #(.W(NUM_LINES)) u_cap (
    .clk(clk), .rst(rst), .line_s(line_s), .pol(pol_q), .mode(mode_q),
    .set_mask(set_mask), .clr_mask(clr_mask), .pend(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_q & en_q);
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              irq_out,
  input logic [W-1:0]      pend_q,
  input logic [W-1:0]      en_q,
  input logic [W-1:0]      mode_q
);
  logic wr_clr, wr_set, rd_zero;
  logic [W-1:0] clr_bits;

  assign wr_clr   = bus_wr && (bus_addr == ADDR_W'(8'h0C));
  assign wr_set   = bus_wr && (bus_addr == ADDR_W'(8'h08));
  assign rd_zero  = bus_rd && ((bus_addr == ADDR_W'(8'h08)) || (bus_addr == ADDR_W'(8'h0C)));
  assign clr_bits = wr_clr ? bus_wdata : '0;

  // R9
  out_follows_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past(|(pend_q & en_q)));

  // R4
  edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_q & mode_q) & ~$past(clr_bits)) & mode_q & ~pend_q) == '0));

  // R8
  set_forces_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((pend_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R2
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_zero |=> bus_rdata == '0);
endmodule

bind irq_aggregator irq_aggregator_chk #(.W(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .pend_q(pend_q), .en_q(en_q), .mode_q(mode_q)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int PERIOD = 10;
  localparam logic [7:0] A_PEND = 8'h00, A_EN = 8'h04, A_SET = 8'h08,
                         A_CLR = 8'h0C, A_POL = 8'h10, A_MODE = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, irq_lines = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk); irq_lines = v; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, acc, pol;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(A_EN, r);   check("R1 en", r, 32'd0);
    rd(A_POL, r);  check("R1 pol", r, 32'd0);
    rd(A_MODE, r); check("R1 mode", r, 32'd0);

    // R3 level sweep, low half active-high, high half active-low
    pol = 32'h0000FFFF;
    wr(A_POL, pol);
    foreach (r[k]) begin end
    for (int p = 0; p < 5; p++) begin
      logic [31:0] pat;
      case (p)
        0: pat = 32'h0; 1: pat = 32'hFFFFFFFF; 2: pat = 32'hA5A55A5A;
        3: pat = 32'h0000FFFF; default: pat = 32'h12345678;
      endcase
      drive(pat); rd(A_PEND, r); check("R3 level pattern", r, ~(pat ^ pol));
    end
    for (int i = 0; i < 32; i++) begin
      drive(32'd1 << i); rd(A_PEND, r); check("R3 walking one", r, ~((32'd1 << i) ^ pol));
    end

    // R10 latency and R9 gating on line 5, level high
    wr(A_POL, 32'hFFFFFFFF);
    drive(32'h0);
    wr(A_EN, 32'h20);
    @(negedge clk); irq_lines = 32'h20;
    repeat (3) @(negedge clk);
    check("R10 not yet after 3 edges", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R10 raised on 4th edge", {31'd0, irq_out}, 32'd1);
    wr(A_EN, 32'h0); @(negedge clk);
    check("R9 masked line", {31'd0, irq_out}, 32'd0);
    rd(A_PEND, r); check("R9 still pending", r, 32'h20);
    wr(A_EN, 32'h20); @(negedge clk);
    check("R9 unmasked", {31'd0, irq_out}, 32'd1);
    drive(32'h0); @(negedge clk);
    check("R9 input gone", {31'd0, irq_out}, 32'd0);
    wr(A_EN, 32'h0);

    // R4 edge sweep: low half rising, high half falling
    wr(A_MODE, 32'hFFFFFFFF);
    wr(A_POL, pol);
    settle();
    wr(A_CLR, 32'hFFFFFFFF);
    acc = 32'h0;
    for (int i = 0; i < 32; i++) begin
      drive(32'd1 << i);
      if (i < 16) acc |= (32'd1 << i);
      rd(A_PEND, r); check("R4 after rise", r, acc);
      drive(32'h0);
      if (i >= 16) acc |= (32'd1 << i);
      rd(A_PEND, r); check("R4 after fall", r, acc);
    end

    // R5 partial and full clear
    wr(A_CLR, 32'h000000F0);
    rd(A_PEND, r); check("R5 partial clear", r, 32'hFFFFFF0F);
    wr(A_CLR, 32'hFFFFFFFF);
    rd(A_PEND, r); check("R5 full clear", r, 32'h0);

    // R6 edge and clear committing on the same edge, line 0 rising
    @(negedge clk); irq_lines = 32'h1;
    @(negedge clk);
    wr(A_CLR, 32'h1);
    rd(A_PEND, r); check("R6 edge wins over clear", r, 32'h1);
    wr(A_CLR, 32'h1);
    rd(A_PEND, r); check("R6 later clear", r, 32'h0);
    drive(32'h0);

    // R8 software set in edge mode
    wr(A_SET, 32'h80000001);
    rd(A_PEND, r); check("R8 set", r, 32'h80000001);
    repeat (2) @(negedge clk);
    rd(A_PEND, r); check("R8 set sticks", r, 32'h80000001);
    wr(A_CLR, 32'hFFFFFFFF);

    // R7 clear on an active level line
    wr(A_MODE, 32'h0);
    wr(A_POL, 32'hFFFFFFFF);
    drive(32'h8);
    wr(A_CLR, 32'h8);
    rd(A_PEND, r); check("R7 level ignores clear", r, 32'h8);
    drive(32'h0);
    rd(A_PEND, r); check("R7 level released", r, 32'h0);

    // R2 register readback
    wr(A_EN, 32'h13579BDF);   rd(A_EN, r);   check("R2 en readback", r, 32'h13579BDF);
    wr(A_POL, 32'hCAFEF00D);  rd(A_POL, r);  check("R2 pol readback", r, 32'hCAFEF00D);
    wr(A_MODE, 32'h0F0F0F0F); rd(A_MODE, r); check("R2 mode readback", r, 32'h0F0F0F0F);
    rd(A_SET, r);  check("R2 set reads zero", r, 32'h0);
    rd(A_CLR, r);  check("R2 clear reads zero", r, 32'h0);
    rd(8'h18, r);  check("R2 unmapped reads zero", r, 32'h0);
    rd(8'h05, r);  check("R2 unaligned reads zero", r, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule